// File: doc/BRIEF.md
# Permuted-Enable Interrupt Status Unit

This unit is the interrupt section of a serial controller. It catches three
single-cycle event pulses from the controller core (a frame sequence finishing,
received data becoming available, and a received word being lost for lack of
room). Each pulse sets a sticky raw status bit, and the bit stays set until
software clears it. A masked view is formed from the raw bits and three enable
bits taken from the controller's control word. The single level interrupt line
is the OR of that masked view.

The enable bits do not sit in the same order as the status bits. The enables
live at control-word bits 4 to 6, and the unit routes each one to its matching
status position before the AND.

Address decoding is done outside the unit, which receives one write strobe per
register. Software clears raw bits by writing ones to the clear register. Writes
aimed at the raw or masked views are accepted on the bus and have no effect.

Top module: `irqmap_top`

## Requirements
- R1: Raw status bit 0 records transfer done, bit 1 records receive ready and bit 2 records receive overrun. An event pulse sets its bit on the next clock edge, and the bit stays set until it is cleared.
- R2: The masked status is always available on `maskStat`. It follows the inputs combinationally: masked bit 0 = raw bit 0 AND control bit 5, masked bit 1 = raw bit 1 AND control bit 4, masked bit 2 = raw bit 2 AND control bit 6. All other control bits have no effect.
- R3: `irq` is high exactly when at least one masked status bit is set.
- R4: A clear write (`wrClr` high) with a 1 in data bit 0, 1 or 2 clears the matching raw bit on the next edge. A 0 in those bits leaves the raw bit unchanged, and data bits 3 and above are ignored.
- R5: When an event and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R6: Write strobes aimed at the raw view (`wrRaw`) or the masked view (`wrMasked`) leave the raw status unchanged, whatever the data.
- R7: While reset is asserted (`rstN` low), and right after it, all raw bits are 0 and `irq` is low.
- R8: Bits 3 and above of `rawStat` and `maskStat` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtDone | input | 1 | Transfer-done event pulse |
| evtRxReady | input | 1 | Receive-ready event pulse |
| evtOverrun | input | 1 | Receive-overrun event pulse |
| ctrlWord | input | CTRL_W | Current control word; bits 4..6 hold the enables |
| wrClr | input | 1 | Write strobe to the clear register |
| wrRaw | input | 1 | Write strobe to the raw status view (ignored) |
| wrMasked | input | 1 | Write strobe to the masked status view (ignored) |
| wrData | input | DATA_W | Bus write data |
| rawStat | output | DATA_W | Raw status view |
| maskStat | output | DATA_W | Masked status view |
| irq | output | 1 | Level interrupt request |

## Verification
The bench enables one control bit at a time. A swapped enable route would then
show up as a masked bit in the wrong place, or as no masked bit at all. It also
sets every control bit except 4 to 6, which catches a mask built from status
positions rather than enable positions. Clear writes are sent with only upper
data bits set, and separately a clear is sent in the same cycle as an event on
the same bit. A design that decoded too wide a clear field would lose status in
the first case, and one that gave priority to the clear would lose status in the
second. Writes aimed at the read-only views carry all-ones data, so a design that
wrote through would show changed raw bits on the next read.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  localparam int NUM_EVT   = 3;
  localparam int EVT_DONE  = 0;
  localparam int EVT_RXRDY = 1;
  localparam int EVT_OVR   = 2;

  // Control-word position of the enable for each raw status bit.
  function automatic int enablePos(input int evtIdx);
    case (evtIdx)
      EVT_DONE:  enablePos = 5;
      EVT_RXRDY: enablePos = 4;
      default:   enablePos = 6;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_EVT-1:0] clrBits;  // per-bit clear request
    logic               roWrite;  // write to a read-only view (no effect)
  } strobe_t;

endpackage

// File: rtl/irqmap_ctrl.sv
module irqmap_ctrl
  import irqmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrClr,
  input  logic              wrRaw,
  input  logic              wrMasked,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strobes
);

  // Only the low bits of the clear data carry meaning.
  logic unusedData;
  assign unusedData = ^wrData;

  always_comb begin
    strobes.clrBits = wrClr ? wrData[NUM_EVT-1:0] : '0;
    strobes.roWrite = wrRaw | wrMasked;
  end

  // Writes to the read-only views never produce a clear request.
  AST_RO_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ((wrRaw || wrMasked) && !wrClr) |-> (strobes.clrBits == '0)) else $error("ro write cleared"); // R6

endmodule

// File: rtl/irqmap_datapath.sv
module irqmap_datapath
  import irqmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic [CTRL_W-1:0]  ctrlWord,
  input  strobe_t            strobes,
  output logic [DATA_W-1:0]  rawStat,
  output logic [DATA_W-1:0]  maskStat,
  output logic               irq
);

  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] rawBits;
  logic [NUM_EVT-1:0] enVec;
  logic [NUM_EVT-1:0] maskBits;

  logic unusedCtrl;
  assign unusedCtrl = ^ctrlWord;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    // Route the enable from its control position to status position i.
    assign enVec[i] = ctrlWord[enablePos(i)];

    always_ff @(posedge clk) begin
      if (!rstN)                    rawBits[i] <= 1'b0;
      else if (evtVec[i])           rawBits[i] <= 1'b1;  // event beats clear
      else if (strobes.clrBits[i])  rawBits[i] <= 1'b0;
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[i] |=> rawBits[i]) else $error("event lost"); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrBits[i] && !evtVec[i]) |=> !rawBits[i]) else $error("clear lost"); // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rawBits[i]) |-> $past(evtVec[i])) else $error("bit set without event"); // R1
  end

  assign maskBits = rawBits & enVec;
  assign irq      = |maskBits;
  assign rawStat  = {{PAD_W{1'b0}}, rawBits};
  assign maskStat = {{PAD_W{1'b0}}, maskBits};

  AST_RO_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.roWrite && strobes.clrBits == '0 && evtVec == '0) |=> $stable(rawBits)) else $error("ro write changed raw"); // R6

endmodule

// File: rtl/irqmap_top.sv
module irqmap_top
  import irqmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtDone,
  input  logic              evtRxReady,
  input  logic              evtOverrun,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              wrClr,
  input  logic              wrRaw,
  input  logic              wrMasked,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rawStat,
  output logic [DATA_W-1:0] maskStat,
  output logic              irq
);

  strobe_t            strobes;
  logic [NUM_EVT-1:0] evtVec;

  assign evtVec[EVT_DONE]  = evtDone;
  assign evtVec[EVT_RXRDY] = evtRxReady;
  assign evtVec[EVT_OVR]   = evtOverrun;

  irqmap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrClr(wrClr), .wrRaw(wrRaw),
    .wrMasked(wrMasked), .wrData(wrData), .strobes(strobes)
  );

  irqmap_datapath #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_dp (
    .clk(clk), .rstN(rstN), .evtVec(evtVec), .ctrlWord(ctrlWord),
    .strobes(strobes), .rawStat(rawStat), .maskStat(maskStat), .irq(irq)
  );

  AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irq == (|maskStat)) else $error("irq mismatch"); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rawStat >> NUM_EVT) == '0 && (maskStat >> NUM_EVT) == '0) else $error("upper bits set"); // R8
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rstN |=> (rawStat == '0 && !irq)) else $error("reset not clean"); // R7

endmodule

// File: tb/tb_irqmap_top.sv
`timescale 1ns/1ps
module tb_irqmap_top;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtDone = 1'b0, evtRxReady = 1'b0, evtOverrun = 1'b0;
  logic [CTRL_W-1:0] ctrlWord = '0;
  logic wrClr = 1'b0, wrRaw = 1'b0, wrMasked = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rawStat, maskStat;
  logic irq;

  always #2 clk = ~clk;  // 250 MHz

  irqmap_top #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) dut (.*);

  typedef struct {
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] msk;
    logic              irqExp;
    string             req;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int fails = 0;
  logic [2:0] modelRaw = '0;

  function automatic logic [DATA_W-1:0] maskOf(logic [2:0] r, logic [CTRL_W-1:0] c);
    maskOf = '0;
    maskOf[0] = r[0] & c[5];
    maskOf[1] = r[1] & c[4];
    maskOf[2] = r[2] & c[6];
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, push the expected post-edge view.
  task automatic step(logic [2:0] evt, logic clr, logic raw, logic msk,
                      logic [DATA_W-1:0] data, logic [CTRL_W-1:0] ctrl, string req);
    item_t it;
    logic [2:0] clrMask;
    @(negedge clk);
    {evtOverrun, evtRxReady, evtDone} = evt;
    wrClr = clr; wrRaw = raw; wrMasked = msk; wrData = data; ctrlWord = ctrl;
    clrMask  = clr ? data[2:0] : 3'b000;
    modelRaw = (modelRaw & ~clrMask) | evt;
    it.raw    = {5'b0, modelRaw};
    it.msk    = maskOf(modelRaw, ctrl);
    it.irqExp = |it.msk;
    it.req    = req;
    expQ.push_back(it);
  endtask

  // Monitor: one cycle after each edge, compare against the queue head.
  always @(posedge clk) begin
    #1;
    if (rstN && expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      check(it.req, rawStat, it.raw, "rawStat");
      check(it.req, maskStat, it.msk, "maskStat");
      check(it.req, {7'b0, irq}, {7'b0, it.irqExp}, "irq");
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        check("R7", rawStat, '0, "rawStat in reset");
        check("R7", {7'b0, irq}, 8'h0, "irq in reset");
        @(negedge clk); rstN = 1'b1;
        step(3'b001, 0, 0, 0, 8'h00, 32'h0, "R1 done, enables off");
        step(3'b000, 0, 0, 0, 8'h00, 32'h20, "R2 done enable at bit5");
        step(3'b010, 0, 0, 0, 8'h00, 32'h20, "R1 rx ready");
        step(3'b000, 0, 0, 0, 8'h00, 32'h10, "R2 rx enable at bit4");
        step(3'b100, 0, 0, 0, 8'h00, 32'h40, "R2 overrun enable at bit6");
        step(3'b000, 0, 0, 0, 8'h00, 32'hFFFF_FF8F, "R2 other ctrl bits no effect");
        step(3'b000, 0, 0, 0, 8'h00, 32'h70, "R3 all enables");
        step(3'b000, 0, 1, 0, 8'h00, 32'h70, "R6 raw view write zeros");
        step(3'b000, 0, 0, 1, 8'h00, 32'h70, "R6 masked view write zeros");
        step(3'b000, 0, 1, 1, 8'hFF, 32'h70, "R6 ro write ones");
        step(3'b000, 1, 0, 0, 8'hF8, 32'h70, "R4 upper data bits ignored");
        step(3'b000, 1, 0, 0, 8'h02, 32'h70, "R4 clear rx ready");
        step(3'b001, 1, 0, 0, 8'h01, 32'h70, "R5 event beats clear");
        step(3'b000, 1, 0, 0, 8'h05, 32'h70, "R4 clear remaining, R3 irq low");
        step(3'b110, 1, 0, 0, 8'h01, 32'h40, "R8 mixed event and clear");
        step(3'b000, 0, 0, 0, 8'h00, 32'h00, "R3 enables off irq low");
        step(3'b000, 0, 0, 0, 8'h00, 32'h10, "R2 rx only");
        @(negedge clk);
        {evtOverrun, evtRxReady, evtDone} = 3'b000; wrClr = 0; wrRaw = 0; wrMasked = 0;
        @(negedge clk);
        @(negedge clk);
        rstN = 1'b0; ctrlWord = 32'h70;
        @(posedge clk); #1;
        check("R7", rawStat, '0, "rawStat after reset");
        check("R7", {7'b0, irq}, 8'h0, "irq after reset");
      end
      begin
        repeat (2000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule